// File: doc/BRIEF.md
# Pad Ownership and Conditioning Controller

This block sits between the I/O ring and the logic that wants to use the chip's general-purpose pads. It controls 99 pads, numbered 0 to 98. For each pad it holds a small configuration: which owner drives the pad, and five conditioning flags. There are three possible owners: the peripheral crossbar, the block's own GPIO output level, or the I/O processor. The block then gives each pad its final output value and output enable. It also returns the pad's input level, after optional inversion, only to the owner that holds the pad.

Configuration arrives one 32-bit word at a time on a valid/ready stream. The word layout is:

| Bits | Field |
|------|-------|
| 31:24 | Pad index |
| 17:16 | Ownership code |
| 4:0 | Flags |

All other bits are ignored. A word is taken on any rising clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low during reset and from the first clock after reset it stays high, so the block never stalls the sender. A producer may hold `cfg_valid` high for back-to-back words, and one word is taken per cycle. The stored configuration changes on the edge that takes the word. The pad outputs are combinational from that stored state, so the new behaviour is visible in the same cycle, right after that edge.

Top module: `padctl_top`

## Requirements
- R1: While reset is held, and immediately after it, every pad has ownership code 00. Then `pad_oe`, `pad_do`, `xbar_di`, `gpio_di` and `iop_di` are all zero, and `cfg_ready` is low during reset and high from the first clock after reset.
- R2: An accepted word loads the pad named in bits 31:24. Bit 16 is the master bit and bit 17 is the first bit; flags bit 0 is drive-low, bit 1 drive-high, bit 2 input-invert, bit 3 output-invert and bit 4 open-drain. The new setting takes effect from that clock edge, and every other pad keeps its setting.
- R3: An accepted word whose pad index is 99 or larger changes no pad.
- R4: Ownership code 01 (master only) gives the pad to the crossbar: the source value and enable are `xbar_do`/`xbar_oe`.
- R5: Ownership code 10 (first only) gives the pad to the I/O processor: the source value and enable are `iop_do`/`iop_oe`.
- R6: Ownership code 11 selects GPIO. With drive-low alone the source is 0 with enable 1; with drive-high alone the source is 1 with enable 1.
- R7: In GPIO mode, with both drive flags set, or with neither set, the output enable is 0.
- R8: Output-invert flips the source value before it reaches the pad.
- R9: With open-drain set, the pad is enabled only when the source enable is 1 and the value after output inversion is 0, and `pad_do` is always 0. Without open-drain, `pad_do` is the inverted-or-not value gated by the enable.
- R10: The pad input, XORed with input-invert, is returned only on the owner's input vector (`xbar_di` for 01, `gpio_di` for 11, `iop_di` for 10). The other two vectors read 0 for that pad.
- R11: A pad with ownership code 00 is undriven (`pad_oe`=0, `pad_do`=0) and returns 0 to all owners, whatever its flags and the owner inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration word ready |
| cfg_data | input | 32 | Packed configuration word |
| xbar_do | input | 99 | Crossbar output value per pad |
| xbar_oe | input | 99 | Crossbar output enable per pad |
| iop_do | input | 99 | I/O processor output value per pad |
| iop_oe | input | 99 | I/O processor output enable per pad |
| pad_di | input | 99 | Raw level seen at each pad |
| pad_do | output | 99 | Final value driven to each pad |
| pad_oe | output | 99 | Final output enable for each pad |
| xbar_di | output | 99 | Conditioned input returned to the crossbar |
| gpio_di | output | 99 | Conditioned input returned to GPIO |
| iop_di | output | 99 | Conditioned input returned to the I/O processor |

## Verification
Each ownership code is tried with its owner's value and enable driven both ways. This separates a wrong selection from a wrong enable path. GPIO is tried with each drive-flag combination, so the two valid levels can be told apart from the two input-only cases. Output invert is tried with and without open-drain, and at both source levels, which shows whether the inversion comes before or after the open-drain gating. Writes to pads 98, 99 and 255, and a check of neighbouring pads after every write, separate correct index decoding from off-by-one errors and from writes that spill onto other pads.

// File: rtl/padctl_pkg.sv
package padctl_pkg;

  localparam int CFG_W      = 32;
  localparam int IDX_LSB    = 24;
  localparam int IDX_W      = 8;
  localparam int OWN_LSB    = 16;
  localparam int FLAG_W     = 5;

  // ownership code: bit 0 = master, bit 1 = first
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_XBAR = 2'b01,
    OWN_IOP  = 2'b10,
    OWN_GPIO = 2'b11
  } owner_e;

  typedef struct packed {
    logic od;    // bit 4
    logic oinv;  // bit 3
    logic iinv;  // bit 2
    logic hi;    // bit 1
    logic lo;    // bit 0
  } pad_flags_t;

  typedef struct packed {
    owner_e     owner;
    pad_flags_t flags;
  } pad_cfg_t;

  function automatic pad_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
    pad_cfg_t c;
    c.owner = owner_e'(word[OWN_LSB +: 2]);
    c.flags = pad_flags_t'(word[FLAG_W-1:0]);
    return c;
  endfunction

endpackage

// File: rtl/padctl_decode.sv
module padctl_decode
  import padctl_pkg::*;
#(
  parameter int NPADS = 99
) (
  input  logic                 cfg_valid,
  input  logic                 cfg_ready,
  input  logic [CFG_W-1:0]     cfg_data,
  output logic [NPADS-1:0]     wr_hit,
  output pad_cfg_t             wr_cfg
);

  logic             accept;
  logic [IDX_W-1:0] pad_idx;
  logic             unused_bits;

  assign accept      = cfg_valid & cfg_ready;
  assign pad_idx     = cfg_data[IDX_LSB +: IDX_W];
  assign wr_cfg      = unpack_cfg(cfg_data);
  assign unused_bits = ^{cfg_data[23:18], cfg_data[15:5]};

  // one strobe per pad; an index beyond the last pad matches none
  for (genvar i = 0; i < NPADS; i++) begin : g_hit
    assign wr_hit[i] = accept && (pad_idx == IDX_W'(i));
  end

endmodule

// File: rtl/padctl_regs.sv
module padctl_regs
  import padctl_pkg::*;
#(
  parameter int NPADS = 99
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPADS-1:0]        wr_hit,
  input  pad_cfg_t                wr_cfg,
  output pad_cfg_t [NPADS-1:0]    cfg_q
);

  for (genvar i = 0; i < NPADS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_hit[i]) begin
        cfg_q[i] <= wr_cfg;
      end
    end
  end

endmodule

// File: rtl/padctl_cell.sv
module padctl_cell
  import padctl_pkg::*;
(
  input  pad_cfg_t cfg,
  input  logic     xbar_do,
  input  logic     xbar_oe,
  input  logic     iop_do,
  input  logic     iop_oe,
  input  logic     pad_di,
  output logic     pad_do,
  output logic     pad_oe,
  output logic     xbar_di,
  output logic     gpio_di,
  output logic     iop_di
);

  logic src_do;
  logic src_oe;
  logic val;
  logic din;

  always_comb begin
    src_do = 1'b0;
    src_oe = 1'b0;
    unique case (cfg.owner)
      OWN_XBAR: begin
        src_do = xbar_do;
        src_oe = xbar_oe;
      end
      OWN_IOP: begin
        src_do = iop_do;
        src_oe = iop_oe;
      end
      OWN_GPIO: begin
        // exactly one drive flag makes an output; both or none is input
        src_do = cfg.flags.hi;
        src_oe = cfg.flags.lo ^ cfg.flags.hi;
      end
      default: begin
        src_do = 1'b0;
        src_oe = 1'b0;
      end
    endcase
  end

  assign val = src_do ^ cfg.flags.oinv;

  always_comb begin
    if (cfg.flags.od) begin
      pad_oe = src_oe & ~val;
      pad_do = 1'b0;
    end else begin
      pad_oe = src_oe;
      pad_do = val & src_oe;
    end
  end

  assign din     = pad_di ^ cfg.flags.iinv;
  assign xbar_di = (cfg.owner == OWN_XBAR) & din;
  assign gpio_di = (cfg.owner == OWN_GPIO) & din;
  assign iop_di  = (cfg.owner == OWN_IOP)  & din;

endmodule

// File: rtl/padctl_top.sv
module padctl_top
  import padctl_pkg::*;
#(
  parameter int NPADS = 99
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [31:0]        cfg_data,
  input  logic [NPADS-1:0]   xbar_do,
  input  logic [NPADS-1:0]   xbar_oe,
  input  logic [NPADS-1:0]   iop_do,
  input  logic [NPADS-1:0]   iop_oe,
  input  logic [NPADS-1:0]   pad_di,
  output logic [NPADS-1:0]   pad_do,
  output logic [NPADS-1:0]   pad_oe,
  output logic [NPADS-1:0]   xbar_di,
  output logic [NPADS-1:0]   gpio_di,
  output logic [NPADS-1:0]   iop_di
);

  logic                   rdy_q;
  logic [NPADS-1:0]       wr_hit;
  pad_cfg_t               wr_cfg;
  pad_cfg_t [NPADS-1:0]   cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign cfg_ready = rdy_q;

  padctl_decode #(.NPADS(NPADS)) u_decode (
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_data  (cfg_data),
    .wr_hit    (wr_hit),
    .wr_cfg    (wr_cfg)
  );

  padctl_regs #(.NPADS(NPADS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    padctl_cell u_cell (
      .cfg     (cfg_q[i]),
      .xbar_do (xbar_do[i]),
      .xbar_oe (xbar_oe[i]),
      .iop_do  (iop_do[i]),
      .iop_oe  (iop_oe[i]),
      .pad_di  (pad_di[i]),
      .pad_do  (pad_do[i]),
      .pad_oe  (pad_oe[i]),
      .xbar_di (xbar_di[i]),
      .gpio_di (gpio_di[i]),
      .iop_di  (iop_di[i])
    );
  end

endmodule

// File: rtl/padctl_chk.sv
module padctl_chk
  import padctl_pkg::*;
#(
  parameter int NPADS = 99
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic                  cfg_ready,
  input  logic [31:0]           cfg_data,
  input  logic [NPADS-1:0]      pad_do,
  input  logic [NPADS-1:0]      pad_oe,
  input  logic [NPADS-1:0]      xbar_di,
  input  logic [NPADS-1:0]      gpio_di,
  input  logic [NPADS-1:0]      iop_di,
  input  logic [NPADS-1:0]      wr_hit,
  input  pad_cfg_t [NPADS-1:0]  cfg_q
);

  localparam logic [IDX_W-1:0] PAD_LIMIT = IDX_W'(NPADS);

  logic [NPADS-1:0] own_none;
  logic [NPADS-1:0] gpio_both;
  logic [NPADS-1:0] od_vec;
  logic             unused_bits;

  for (genvar i = 0; i < NPADS; i++) begin : g_vec
    assign own_none[i]  = (cfg_q[i].owner == OWN_NONE);
    assign gpio_both[i] = (cfg_q[i].owner == OWN_GPIO) & cfg_q[i].flags.lo & cfg_q[i].flags.hi;
    assign od_vec[i]    = cfg_q[i].flags.od;
  end

  assign unused_bits = ^{cfg_data[23:18], cfg_data[15:5]};

  logic             wr_q;
  logic [IDX_W-1:0] wr_pad_q;
  pad_cfg_t         wr_cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      wr_pad_q <= '0;
      wr_cfg_q <= '0;
    end else begin
      wr_q     <= cfg_valid && cfg_ready && (cfg_data[31:24] < PAD_LIMIT);
      wr_pad_q <= cfg_data[31:24];
      wr_cfg_q <= unpack_cfg(cfg_data);
    end
  end

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cfg_ready);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (cfg_q[wr_pad_q] == wr_cfg_q));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R3
  range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && (cfg_data[31:24] >= PAD_LIMIT)) |=> $stable(cfg_q));

  // R7
  gpio_both_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & gpio_both) == '0);

  // R9
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & od_vec) == '0);

  // R10
  input_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((xbar_di & gpio_di) | (xbar_di & iop_di) | (gpio_di & iop_di)) == '0);

  // R11
  none_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_do | xbar_di | gpio_di | iop_di) & own_none) == '0);

endmodule

bind padctl_top padctl_chk #(.NPADS(NPADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_data  (cfg_data),
  .pad_do    (pad_do),
  .pad_oe    (pad_oe),
  .xbar_di   (xbar_di),
  .gpio_di   (gpio_di),
  .iop_di    (iop_di),
  .wr_hit    (wr_hit),
  .cfg_q     (cfg_q)
);

// File: tb/padctl_top_tb.sv
`timescale 1ns/1ps
module padctl_top_tb;

  localparam int N = 99;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [31:0]   cfg_data = '0;
  logic [N-1:0]  xbar_do = '0, xbar_oe = '0, iop_do = '0, iop_oe = '0, pad_di = '0;
  logic [N-1:0]  pad_do, pad_oe, xbar_di, gpio_di, iop_di;

  always #4 clk = ~clk;  // 125 MHz

  padctl_top #(.NPADS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .xbar_do(xbar_do), .xbar_oe(xbar_oe), .iop_do(iop_do),
    .iop_oe(iop_oe), .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe),
    .xbar_di(xbar_di), .gpio_di(gpio_di), .iop_di(iop_di)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] sh_own [N];
  logic [4:0] sh_fl  [N];

  typedef struct {
    int         pad;
    logic [4:0] exp;  // {do, oe, xdi, gdi, idi}
    string      tag;
  } item_t;
  item_t q[$];

  function automatic logic [4:0] model(input logic [1:0] own, input logic [4:0] fl,
                                       input logic xd, xo, id, io, di);
    logic sd, so, v, o_do, o_oe, din;
    sd = 1'b0; so = 1'b0;
    case (own)
      2'b01: begin sd = xd; so = xo; end
      2'b10: begin sd = id; so = io; end
      2'b11: begin sd = fl[1]; so = fl[0] ^ fl[1]; end
      default: begin sd = 1'b0; so = 1'b0; end
    endcase
    v = sd ^ fl[3];
    if (fl[4]) begin o_oe = so & ~v; o_do = 1'b0; end
    else       begin o_oe = so;      o_do = v & so; end
    din = di ^ fl[2];
    return {o_do, o_oe, (own == 2'b01) & din, (own == 2'b11) & din, (own == 2'b10) & din};
  endfunction

  task automatic cfg_write(input int pad, input logic [1:0] own, input logic [4:0] fl);
    @(posedge clk); #1;
    cfg_valid = 1'b1;
    cfg_data  = {8'(pad), 6'b101010, own, 8'hA5, 3'b110, fl};  // junk in ignored bits
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    if (pad < N) begin sh_own[pad] = own; sh_fl[pad] = fl; end
  endtask

  task automatic set_src(input int pad, input logic xd, xo, id, io, di);
    xbar_do[pad] = xd; xbar_oe[pad] = xo; iop_do[pad] = id; iop_oe[pad] = io; pad_di[pad] = di;
  endtask

  task automatic expect_pad(input int pad, input string tag);
    item_t it;
    it.pad = pad;
    it.tag = tag;
    it.exp = model(sh_own[pad], sh_fl[pad], xbar_do[pad], xbar_oe[pad],
                   iop_do[pad], iop_oe[pad], pad_di[pad]);
    q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it  = q.pop_front();
        act = {pad_do[it.pad], pad_oe[it.pad], xbar_di[it.pad], gpio_di[it.pad], iop_di[it.pad]};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s pad %0d: got %b expected %b", it.tag, it.pad, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin sh_own[i] = 2'b00; sh_fl[i] = 5'b0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state with owner inputs active
    xbar_do = '1; xbar_oe = '1; iop_do = '1; iop_oe = '1; pad_di = '1;
    settle();
    checks++;
    if ((pad_oe | pad_do | xbar_di | gpio_di | iop_di) !== '0 || cfg_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got oe=%h rdy=%b expected 0", pad_oe, cfg_ready);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    settle();
    checks++;
    if (cfg_ready !== 1'b1 || pad_oe !== '0) begin
      fails++;
      $display("FAIL R1 after reset: got rdy=%b expected 1", cfg_ready);
    end
    xbar_do = '0; xbar_oe = '0; iop_do = '0; iop_oe = '0; pad_di = '0;

    // R4 crossbar owner
    cfg_write(10, 2'b01, 5'b00000);
    set_src(10, 1, 1, 0, 0, 1); expect_pad(10, "R4 xbar drive"); settle();
    set_src(10, 1, 0, 1, 1, 0); expect_pad(10, "R4 xbar disabled"); settle();
    // R5 I/O processor owner
    cfg_write(20, 2'b10, 5'b00000);
    set_src(20, 0, 1, 1, 1, 1); expect_pad(20, "R5 iop drive"); settle();
    set_src(20, 1, 1, 0, 1, 0); expect_pad(20, "R5 iop low"); settle();
    // R6 GPIO levels
    cfg_write(30, 2'b11, 5'b00010);
    set_src(30, 0, 0, 0, 0, 1); expect_pad(30, "R6 gpio high"); settle();
    cfg_write(31, 2'b11, 5'b00001);
    expect_pad(31, "R6 gpio low"); expect_pad(30, "R2 neighbour kept"); settle();
    // R7 GPIO input cases
    cfg_write(32, 2'b11, 5'b00011);
    set_src(32, 1, 1, 1, 1, 1); expect_pad(32, "R7 gpio both"); settle();
    cfg_write(33, 2'b11, 5'b00000);
    expect_pad(33, "R7 gpio neither"); settle();
    // R8 output invert
    cfg_write(40, 2'b01, 5'b01000);
    set_src(40, 0, 1, 0, 0, 0); expect_pad(40, "R8 invert to 1"); settle();
    set_src(40, 1, 1, 0, 0, 0); expect_pad(40, "R8 invert to 0"); settle();
    // R9 open drain, inversion before gating
    cfg_write(41, 2'b11, 5'b11010);
    expect_pad(41, "R9 od pull low after invert"); settle();
    cfg_write(42, 2'b11, 5'b10010);
    expect_pad(42, "R9 od release on high"); settle();
    cfg_write(43, 2'b01, 5'b10000);
    set_src(43, 0, 0, 0, 0, 0); expect_pad(43, "R9 od source disabled"); settle();
    // R10 input invert routed to owner only
    cfg_write(50, 2'b10, 5'b00100);
    set_src(50, 1, 1, 0, 0, 0); expect_pad(50, "R10 iop inverted input"); settle();
    cfg_write(51, 2'b01, 5'b00000);
    set_src(51, 0, 0, 0, 0, 1); expect_pad(51, "R10 xbar plain input"); settle();
    // R2 boundary pad and overwrite
    cfg_write(98, 2'b11, 5'b00010);
    expect_pad(98, "R2 last pad"); expect_pad(97, "R2 pad below last"); settle();
    cfg_write(10, 2'b10, 5'b00000);
    set_src(10, 1, 1, 1, 1, 1); expect_pad(10, "R2 overwrite"); settle();
    // R3 out-of-range writes
    cfg_write(99, 2'b01, 5'b00001);
    expect_pad(98, "R3 index 99"); expect_pad(0, "R3 index 99 pad0"); settle();
    cfg_write(255, 2'b00, 5'b00000);
    expect_pad(98, "R3 index 255"); expect_pad(10, "R3 index 255 pad10"); settle();
    // R11 release to none
    cfg_write(30, 2'b00, 5'b11111);
    set_src(30, 1, 1, 1, 1, 1); expect_pad(30, "R11 undriven"); settle();

    settle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule